// File: doc/BRIEF.md
# Speculative Read Queue with Cancel and Backpressure Hysteresis

This block holds up to 31 speculative memory reads in arrival order and offers the oldest one to a downstream scheduler. Each read carries a tag and an address. Any read still waiting can be withdrawn by tag, for example after a write-back hit, an explicit cancel, a coherency conflict or a retried request. Its slot is freed at once and the younger entries close the gap, so their order is kept.

When the scheduler accepts the head entry, that read is committed and leaves the queue. Its tag stays outstanding until the matching data response comes back. A cancel that reaches a committed read cannot stop the access. It only marks the tag, and the response for that tag is then flagged for discard.

Backpressure toward the requester uses hysteresis. It turns on when 27 reads are held. It turns off only once occupancy has fallen to 20 or below. In between it keeps its previous value, so the flow-control line does not chatter near the threshold.

Top module: `spec_read_queue`

## Requirements
- R1: After reset the queue is empty: `occupancy` is 0, `deq_valid` is 0 and `backpressure` is 0.
- R2: Accepted reads are presented on `deq_tag`/`deq_addr` oldest first. `deq_valid` is high exactly when `occupancy` is nonzero.
- R3: A cycle with `deq_valid` and `deq_ready` both high commits the head read. The next cycle shows the following entry at the head, and occupancy is one lower.
- R4: An enqueue while occupancy is 31 is ignored, even if a commit happens in the same cycle. Occupancy never exceeds 31.
- R5: `backpressure` is high in every cycle in which occupancy is 27 or more.
- R6: Once on, `backpressure` stays high until occupancy is 20 or less, and then drops. While occupancy is between 21 and 26 it keeps its previous value.
- R7: A cancel whose tag matches a waiting, uncommitted entry removes that entry. From the next cycle occupancy is one lower and the remaining entries keep their relative order.
- R8: Enqueue, cancel and commit in the same cycle change occupancy by their net effect: plus one for an accepted enqueue, minus one for each removal. Occupancy rises by at most one per cycle.
- R9: A cancel that hits a committed, outstanding tag does not change the queue. This includes a tag committed in the same cycle as the cancel. The later response for that tag has `rsp_drop` high in the cycle `rsp_valid` presents it.
- R10: A response for an outstanding tag that was not cancelled has `rsp_drop` low. Any response retires the tag, so a later commit of the same tag starts unmarked.
- R11: A cancel whose tag matches no waiting entry and no outstanding tag is ignored. Occupancy and the head stay unchanged, and no later response is marked because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | 1 | New speculative read offered |
| enq_tag | input | 5 | Tag of the new read |
| enq_addr | input | 32 | Address of the new read |
| cxl_valid | input | 1 | Cancel request for a tag |
| cxl_tag | input | 5 | Tag to cancel |
| deq_valid | output | 1 | Head read available to the scheduler |
| deq_tag | output | 5 | Tag of the head read |
| deq_addr | output | 32 | Address of the head read |
| deq_ready | input | 1 | Scheduler commits the head read |
| rsp_valid | input | 1 | Data response for an outstanding tag |
| rsp_tag | input | 5 | Tag of the response |
| rsp_drop | output | 1 | Response data must be discarded (late cancel) |
| backpressure | output | 1 | Stop sending reads (hysteresis) |
| occupancy | output | 5 | Number of reads waiting |

## Verification
The checker watches several invariants on every cycle. Backpressure is on at or above the upper level and off at or below the lower level, and it holds its value between them. Occupancy never passes the depth and never rises by more than one per cycle. The head-valid flag agrees with occupancy, and a discard flag only appears alongside a response. Other behaviour can only be shown by the bench's scenarios compared against its reference model. This covers whether the right entry leaves on a cancel, whether the survivors keep their order, and whether a cancel at or after commit leads to a discarded response. It also covers whether stray cancels leave no trace on later responses.

// File: rtl/rdq_pkg.sv
package rdq_pkg;

    localparam int TAG_W  = 5;
    localparam int ADDR_W = 32;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
    } rd_ent_t;

    // Hysteresis step: set at/above the high mark, clear at/below the low mark.
    function automatic logic bp_step(logic cur, int unsigned lvl,
                                     int unsigned hi, int unsigned lo);
        if (lvl >= hi)      return 1'b1;
        else if (lvl <= lo) return 1'b0;
        else                return cur;
    endfunction

endpackage

// File: rtl/rdq_slots.sv
module rdq_slots
    import rdq_pkg::*;
#(
    parameter int DEPTH = 31,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  rd_ent_t          push_ent,
    input  logic             pop,
    input  logic             cxl_valid,
    input  logic [TAG_W-1:0] cxl_tag,
    output rd_ent_t          head,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt,
    output logic             cxl_removed,
    output logic             cxl_at_commit
);

    rd_ent_t slot [DEPTH];
    rd_ent_t nxt  [DEPTH];

    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [CNT_W-1:0] wr;

    // Oldest live entry carrying the cancel tag.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (cxl_valid && !hit && slot[j].vld && slot[j].tag == cxl_tag) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(j);
            end
        end
    end

    assign cxl_at_commit = hit && (hit_idx == '0) && pop;
    assign cxl_removed   = hit && !cxl_at_commit;

    // Compact survivors toward slot 0, then append the new entry.
    always_comb begin
        nxt = '{default: '0};
        wr  = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (slot[j].vld &&
                !((j == 0) && pop) &&
                !(cxl_removed && hit_idx == IDX_W'(j))) begin
                nxt[wr[IDX_W-1:0]] = slot[j];
                wr = wr + CNT_W'(1);
            end
        end
        if (push) begin
            nxt[wr[IDX_W-1:0]] = push_ent;
            wr = wr + CNT_W'(1);
        end
        count_nxt = wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) slot[j] <= '0;
            count <= '0;
        end else begin
            slot  <= nxt;
            count <= count_nxt;
        end
    end

    assign head = slot[0];

endmodule

// File: rtl/rdq_bp.sv
module rdq_bp
    import rdq_pkg::*;
#(
    parameter int DEPTH  = 31,
    parameter int BP_ON  = 27,
    parameter int BP_OFF = 20,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count_nxt,
    output logic             bp
);

    always_ff @(posedge clk) begin
        if (rst) bp <= 1'b0;
        else     bp <= bp_step(bp, int'(count_nxt), BP_ON, BP_OFF);
    end

endmodule

// File: rtl/rdq_track.sv
module rdq_track
    import rdq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [TAG_W-1:0] commit_tag,
    input  logic             cxl_valid,
    input  logic [TAG_W-1:0] cxl_tag,
    input  logic             cxl_removed,
    input  logic             cxl_at_commit,
    input  logic             rsp_valid,
    input  logic [TAG_W-1:0] rsp_tag,
    output logic             rsp_drop
);

    localparam int NTAG = 1 << TAG_W;

    logic [NTAG-1:0] outst;
    logic [NTAG-1:0] disc;
    logic            late;
    logic            rsp_hit;

    assign late    = cxl_valid && !cxl_removed && (cxl_at_commit || outst[cxl_tag]);
    assign rsp_hit = rsp_valid && outst[rsp_tag];

    always_ff @(posedge clk) begin
        if (rst) begin
            outst <= '0;
            disc  <= '0;
        end else begin
            if (rsp_hit) begin
                outst[rsp_tag] <= 1'b0;
                disc[rsp_tag]  <= 1'b0;
            end
            if (commit) begin
                outst[commit_tag] <= 1'b1;
                disc[commit_tag]  <= 1'b0;
            end
            if (late) disc[cxl_tag] <= 1'b1;
        end
    end

    assign rsp_drop = rsp_hit && disc[rsp_tag];

endmodule

// File: rtl/spec_read_queue.sv
module spec_read_queue
    import rdq_pkg::*;
#(
    parameter int DEPTH  = 31,
    parameter int BP_ON  = 27,
    parameter int BP_OFF = 20,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    input  logic [TAG_W-1:0]  enq_tag,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic              cxl_valid,
    input  logic [TAG_W-1:0]  cxl_tag,
    output logic              deq_valid,
    output logic [TAG_W-1:0]  deq_tag,
    output logic [ADDR_W-1:0] deq_addr,
    input  logic              deq_ready,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_drop,
    output logic              backpressure,
    output logic [CNT_W-1:0]  occupancy
);

    rd_ent_t          head;
    rd_ent_t          in_ent;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             push;
    logic             pop;
    logic             cxl_rm;
    logic             cxl_commit;

    assign in_ent = '{vld: 1'b1, tag: enq_tag, addr: enq_addr};
    assign push   = enq_valid && (cnt < CNT_W'(DEPTH));
    assign pop    = deq_ready && head.vld;

    rdq_slots #(.DEPTH(DEPTH)) u_slots (
        .clk          (clk),
        .rst          (rst),
        .push         (push),
        .push_ent     (in_ent),
        .pop          (pop),
        .cxl_valid    (cxl_valid),
        .cxl_tag      (cxl_tag),
        .head         (head),
        .count        (cnt),
        .count_nxt    (cnt_nxt),
        .cxl_removed  (cxl_rm),
        .cxl_at_commit(cxl_commit)
    );

    rdq_bp #(.DEPTH(DEPTH), .BP_ON(BP_ON), .BP_OFF(BP_OFF)) u_bp (
        .clk      (clk),
        .rst      (rst),
        .count_nxt(cnt_nxt),
        .bp       (backpressure)
    );

    rdq_track u_track (
        .clk          (clk),
        .rst          (rst),
        .commit       (pop),
        .commit_tag   (head.tag),
        .cxl_valid    (cxl_valid),
        .cxl_tag      (cxl_tag),
        .cxl_removed  (cxl_rm),
        .cxl_at_commit(cxl_commit),
        .rsp_valid    (rsp_valid),
        .rsp_tag      (rsp_tag),
        .rsp_drop     (rsp_drop)
    );

    assign deq_valid = head.vld;
    assign deq_tag   = head.tag;
    assign deq_addr  = head.addr;
    assign occupancy = cnt;

endmodule

// File: rtl/spec_read_queue_chk.sv
module spec_read_queue_chk #(
    parameter int DEPTH  = 31,
    parameter int BP_ON  = 27,
    parameter int BP_OFF = 20,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             deq_valid,
    input logic             rsp_valid,
    input logic             rsp_drop,
    input logic             backpressure,
    input logic [CNT_W-1:0] occupancy
);

    localparam logic [CNT_W-1:0] HI  = CNT_W'(BP_ON);
    localparam logic [CNT_W-1:0] LO  = CNT_W'(BP_OFF);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

    // R5
    bp_on_chk: assert property (@(posedge clk) disable iff (rst)
        occupancy >= HI |-> backpressure);

    // R6
    bp_off_chk: assert property (@(posedge clk) disable iff (rst)
        occupancy <= LO |-> !backpressure);

    // R6
    bp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (occupancy > LO && occupancy < HI) |-> backpressure == $past(backpressure));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occupancy <= TOP);

    // R8
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        {1'b0, occupancy} <= {1'b0, $past(occupancy)} + 1'b1);

    // R2
    head_valid_chk: assert property (@(posedge clk) disable iff (rst)
        deq_valid == (occupancy != '0));

    // R9
    drop_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_drop |-> rsp_valid);

endmodule

bind spec_read_queue spec_read_queue_chk #(
    .DEPTH (DEPTH),
    .BP_ON (BP_ON),
    .BP_OFF(BP_OFF)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .deq_valid   (deq_valid),
    .rsp_valid   (rsp_valid),
    .rsp_drop    (rsp_drop),
    .backpressure(backpressure),
    .occupancy   (occupancy)
);

// File: tb/spec_read_queue_tb.sv
module spec_read_queue_tb;

    localparam int DEPTH = 31;
    localparam int HI    = 27;
    localparam int LO    = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enq_valid = 1'b0;
    logic [4:0]  enq_tag = '0;
    logic [31:0] enq_addr = '0;
    logic        cxl_valid = 1'b0;
    logic [4:0]  cxl_tag = '0;
    logic        deq_valid;
    logic [4:0]  deq_tag;
    logic [31:0] deq_addr;
    logic        deq_ready = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [4:0]  rsp_tag = '0;
    logic        rsp_drop;
    logic        backpressure;
    logic [5:0]  occ6;
    logic [4:0]  occupancy;

    assign occ6 = {1'b0, occupancy};

    spec_read_queue u_dut (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_tag(enq_tag), .enq_addr(enq_addr),
        .cxl_valid(cxl_valid), .cxl_tag(cxl_tag),
        .deq_valid(deq_valid), .deq_tag(deq_tag), .deq_addr(deq_addr),
        .deq_ready(deq_ready),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_drop(rsp_drop),
        .backpressure(backpressure), .occupancy(occupancy)
    );

    always #10 clk = ~clk;

    typedef struct { int tag; int addr; } ent_t;
    ent_t q[$];
    bit   outst [32];
    bit   disc  [32];
    bit   m_bp;
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    task automatic chk(bit ok, string r, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    // One clock: drive, compare against the model, advance the model.
    task automatic cyc(string r, bit ev, int et, int ea, bit cv, int ct,
                       bit dr, bit rv, int rt);
        int  n;
        int  ci;
        bit  fire;
        bit  acc;
        bit  late;
        bit  exp_drop;
        enq_valid = ev; enq_tag = 5'(et); enq_addr = 32'(ea);
        cxl_valid = cv; cxl_tag = 5'(ct);
        deq_ready = dr; rsp_valid = rv; rsp_tag = 5'(rt);
        #2;
        n = q.size();
        exp_drop = rv && outst[rt] && disc[rt];
        chk(int'(occ6) == n, r, "occupancy", int'(occ6), n);
        chk(deq_valid == (n > 0), r, "deq_valid", int'(deq_valid), int'(n > 0));
        if (n > 0) begin
            chk(int'(deq_tag) == q[0].tag, r, "deq_tag", int'(deq_tag), q[0].tag);
            chk(deq_addr == 32'(q[0].addr), r, "deq_addr", int'(deq_addr), q[0].addr);
        end
        chk(backpressure == m_bp, r, "backpressure", int'(backpressure), int'(m_bp));
        chk(rsp_drop == exp_drop, r, "rsp_drop", int'(rsp_drop), int'(exp_drop));
        @(posedge clk);
        fire = dr && n > 0;
        acc  = ev && n < DEPTH;
        ci   = -1;
        if (cv) begin
            for (int i = 0; i < n; i++)
                if (ci < 0 && q[i].tag == ct) ci = i;
        end
        late = cv && ((ci == 0 && fire) || (ci < 0 && outst[ct]));
        if (rv && outst[rt]) begin outst[rt] = 0; disc[rt] = 0; end
        if (fire) begin outst[q[0].tag] = 1; disc[q[0].tag] = 0; end
        if (late) disc[ct] = 1;
        if (cv && ci >= 0 && !(ci == 0 && fire)) q.delete(ci);
        if (fire) void'(q.pop_front());
        if (acc) q.push_back('{tag: et, addr: ea});
        n = q.size();
        if (n >= HI) m_bp = 1;
        else if (n <= LO) m_bp = 0;
        @(negedge clk);
    endtask

    task automatic idle(string r);
        cyc(r, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic put(string r, int t);
        cyc(r, 1, t, 32'h1000 + t * 64, 0, 0, 0, 0, 0);
    endtask
    task automatic take(string r);
        cyc(r, 0, 0, 0, 0, 0, 1, 0, 0);
    endtask
    task automatic kill(string r, int t);
        cyc(r, 0, 0, 0, 1, t, 0, 0, 0);
    endtask
    task automatic resp(string r, int t);
        cyc(r, 0, 0, 0, 0, 0, 0, 1, t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle("R1 reset state");

        // R2 order, R3 commit
        put("R2", 1); put("R2", 2); put("R2", 3);
        take("R3"); take("R3"); take("R3");
        resp("R10", 1); resp("R10", 2); resp("R10", 3);

        // R9 cancel in the commit cycle, then cancel after commit
        put("R9", 5);
        cyc("R9 cancel at commit", 0, 0, 0, 1, 5, 1, 0, 0);
        resp("R9 drop expected", 5);
        put("R9", 6); take("R9"); kill("R9 late", 6);
        resp("R9 drop expected", 6);
        // R10 plain response
        put("R10", 7); take("R10"); resp("R10 no drop", 7);

        // R11 stray cancels
        put("R11", 8); put("R11", 9);
        kill("R11 unknown tag", 20);
        kill("R11 retired tag", 7);
        idle("R11");
        take("R11"); take("R11");
        put("R11", 7); take("R11"); resp("R11 no stale mark", 7);
        resp("R11", 8); resp("R11", 9);

        // R7 cancel in the middle, R8 net effect
        for (int t = 10; t <= 14; t++) put("R7", t);
        kill("R7 middle", 12);
        cyc("R8 enq+cancel", 1, 15, 32'h5150, 1, 11, 0, 0, 0);
        cyc("R8 enq+cancel+commit", 1, 16, 32'h5160, 1, 13, 1, 0, 0);
        idle("R8");
        while (q.size() > 0) take("R7 drain order");

        // R5 fill, R4 full, R6 hysteresis both directions
        for (int t = 0; t < DEPTH; t++) put("R5 fill", t);
        put("R4 enq at full", 31);
        cyc("R4 enq+commit at full", 1, 31, 32'h7777, 0, 0, 1, 0, 0);
        idle("R4");
        while (q.size() > 19) take("R6 drain");
        for (int t = 0; t < 7; t++) put("R6 refill below on-level", t);
        idle("R6");
        while (q.size() > 0) take("R6");
        for (int t = 0; t < 32; t++) resp("R10 retire", t);

        // Mixed traffic, all requirements
        for (int k = 0; k < 4000; k++) begin
            bit ev = ($urandom % 100) < 55;
            bit cv = ($urandom % 100) < 25;
            bit dr = ($urandom % 100) < 40;
            bit rv = ($urandom % 100) < 30;
            cyc("R2-mix R7-mix R8-mix R9-mix R11-mix", ev, int'($urandom % 32),
                int'($urandom % 65536), cv, int'($urandom % 32), dr, rv,
                int'($urandom % 32));
        end
        while (q.size() > 0) take("R3 final drain");
        idle("R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule